// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block runs one analogue-to-digital conversion at a time over a simple parallel converter interface. A conversion goes through two phases in a fixed order. In the convert phase, chip select is active and the read/convert line sits at its convert level. In the read phase, the read/convert line moves to its read level and the result word is captured. A single-cycle software start pulse begins a conversion. So does a programmed edge on the selected one of three asynchronous trigger inputs. A request is dropped when a conversion is already running, or when the neighbouring DAC path reports that it is busy.

The convert phase ends in one of two ways. In closed-loop mode it ends on the programmed edge of the converter's ready line, and a timeout counter bounds the wait. When the timeout runs out, the block raises a sticky flag and goes back to idle without touching the result. In open-loop mode the ready line is ignored and the phase ends after a programmed number of cycles. The result is taken as a full 16-bit word or as a zero-extended low byte. Chip select polarity is programmable.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, busy, done, tmo_flag, adc_rc and data_out are 0, and adc_cs sits at its inactive level (the inverse of cs_act_high).
- R2: While idle, a sw_start pulse with dac_busy low puts the block in the convert phase at the next clock edge: busy is 1, adc_rc is 0 (convert level) and adc_cs equals cs_act_high.
- R3: Trigger input k (0 to 2) starts a conversion only when trig_sel equals k. Its active edge is rising when trig_fall[k] is 0 and falling when it is 1. busy rises on the third clock edge after the pin changes. Inactive edges, edges on other inputs, and any edge while trig_sel is 3 start nothing.
- R4: A start request is ignored while busy is 1 or while dac_busy is 1. Ignoring a request mid-conversion leaves the phase lengths unchanged.
- R5: In closed-loop mode (open_loop = 0), the active ready edge (rising when rdy_fall is 0, falling when it is 1) moves the block to the read phase, where adc_rc is 1. This happens if the synchronised edge arrives no later than the last timeout cycle. An edge made when the convert phase has lasted j cycles gives j+2 convert cycles.
- R6: In closed-loop mode with no ready edge in time, the convert phase lasts max(tmo_len,1) cycles. The block then returns to idle with no read phase and no done pulse, and data_out is unchanged. tmo_flag is set and stays at 1 until a tmo_clr pulse.
- R7: In open-loop mode, the convert phase lasts exactly max(conv_len,1) cycles, and the ready input has no effect.
- R8: The read phase lasts max(hold_len,1) cycles. On the cycle after it, busy is 0 and done is 1 for exactly one cycle, and data_out shows the word sampled in the last read cycle.
- R9: With wide_mode 1, data_out is the whole 16-bit input. With wide_mode 0, it is the low 8 bits with the upper 8 bits zero.
- R10: adc_cs equals cs_act_high while busy and its inverse while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_trig_in | input | 3 | Asynchronous trigger pins |
| trig_sel | input | 2 | Selected trigger, 0 to 2; 3 disables the triggers |
| trig_fall | input | 3 | Per trigger: 1 selects the falling edge |
| sw_start | input | 1 | Software start pulse |
| dac_busy | input | 1 | DAC path busy; blocks new starts |
| rdy_in | input | 1 | Asynchronous converter ready |
| rdy_fall | input | 1 | 1 selects the falling ready edge |
| open_loop | input | 1 | 1 ends the convert phase on the duration counter |
| conv_len | input | 16 | Open-loop convert duration in cycles |
| tmo_len | input | 16 | Ready timeout in cycles |
| hold_len | input | 16 | Read phase length in cycles |
| cs_act_high | input | 1 | Chip select active level |
| wide_mode | input | 1 | 1 captures 16 bits, 0 captures 8 bits |
| adc_data_in | input | 16 | Converter data bus |
| tmo_clr | input | 1 | Clears the timeout flag |
| adc_cs | output | 1 | Chip select |
| adc_rc | output | 1 | Read/convert: 0 convert, 1 read |
| busy | output | 1 | Conversion in progress |
| data_out | output | 16 | Captured result |
| done | output | 1 | One-cycle result strobe |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
The assertions check the cycle-local rules on every clock. A start moves the block straight into the convert phase with the convert level, and a phase change puts read/convert at its read level. The end of the read phase coincides with idle and a single done cycle. Data changes only with done, and a timeout gives idle with the flag and no strobe. The bench scenarios check the timing that spans many cycles: the exact lengths of the convert and read phases for random durations, the latency of the synchroniser, which trigger edges and polarities start a conversion, the 8-bit and 16-bit capture values, and the race between a late ready edge and the timeout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_t;

  localparam int unsigned NUM_TRIG = 3;

  // Edge of the programmed polarity between two synchronised samples.
  function automatic logic edge_hit(input logic prev, input logic cur, input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] edge_out
);
  import adc_seq_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pin_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign edge_out[i] = edge_hit(s3, s2, fall_sel[i]);
  end

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  // A loaded value of 0 or 1 both give a one-cycle phase.
  function automatic logic last_tick(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (run && cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign last = last_tick(cnt);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [adc_seq_pkg::NUM_TRIG-1:0]   conv_trig_in,
  input  logic [SEL_W-1:0]                   trig_sel,
  input  logic [adc_seq_pkg::NUM_TRIG-1:0]   trig_fall,
  input  logic                               sw_start,
  input  logic                               dac_busy,
  input  logic                               rdy_in,
  input  logic                               rdy_fall,
  input  logic                               open_loop,
  input  logic [CNT_W-1:0]                   conv_len,
  input  logic [CNT_W-1:0]                   tmo_len,
  input  logic [CNT_W-1:0]                   hold_len,
  input  logic                               cs_act_high,
  input  logic                               wide_mode,
  input  logic [DATA_W-1:0]                  adc_data_in,
  input  logic                               tmo_clr,
  output logic                               adc_cs,
  output logic                               adc_rc,
  output logic                               busy,
  output logic [DATA_W-1:0]                  data_out,
  output logic                               done,
  output logic                               tmo_flag
);
  import adc_seq_pkg::*;

  localparam int unsigned NARROW_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] fmt_data(input logic [DATA_W-1:0] raw, input logic wide);
    return wide ? raw : {{(DATA_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]};
  endfunction

  phase_t state;
  logic [NUM_TRIG-1:0] trig_edge;
  logic                rdy_edge;
  logic                trig_hit;
  logic                start_go, rdy_go, conv_last, to_read, tmo_hit, read_done;
  logic                tmr_last, tmr_load;
  logic [CNT_W-1:0]    tmr_val;

  adc_edge_sync #(.W(NUM_TRIG)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(conv_trig_in), .fall_sel(trig_fall), .edge_out(trig_edge)
  );

  adc_edge_sync #(.W(1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(rdy_in), .fall_sel(rdy_fall), .edge_out(rdy_edge)
  );

  always_comb begin
    trig_hit = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++)
      if (trig_sel == SEL_W'(i)) trig_hit = trig_hit | trig_edge[i];
  end

  // Phase events, named for the checker.
  assign start_go  = (state == PH_IDLE) && !dac_busy && (sw_start || trig_hit);
  assign rdy_go    = (state == PH_CONV) && !open_loop && rdy_edge;
  assign conv_last = (state == PH_CONV) && tmr_last;
  assign to_read   = rdy_go || (conv_last && open_loop);
  assign tmo_hit   = conv_last && !open_loop && !rdy_go;
  assign read_done = (state == PH_READ) && tmr_last;

  assign tmr_load = start_go || to_read;
  assign tmr_val  = start_go ? (open_loop ? conv_len : tmo_len) : hold_len;

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(state != PH_IDLE), .last(tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE: if (start_go)          state <= PH_CONV;
        PH_CONV: if (to_read)           state <= PH_READ;
                 else if (tmo_hit)      state <= PH_IDLE;
        PH_READ: if (read_done)         state <= PH_IDLE;
        default:                        state <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      done     <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      done <= read_done;
      if (read_done) data_out <= fmt_data(adc_data_in, wide_mode);
      if (tmo_hit)      tmo_flag <= 1'b1;
      else if (tmo_clr) tmo_flag <= 1'b0;
    end
  end

  assign busy   = (state != PH_IDLE);
  assign adc_rc = (state == PH_READ);
  assign adc_cs = busy ? cs_act_high : ~cs_act_high;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_start,
  input logic              dac_busy,
  input logic              busy,
  input logic              adc_cs,
  input logic              adc_rc,
  input logic              cs_act_high,
  input logic              done,
  input logic              tmo_flag,
  input logic              tmo_clr,
  input logic [DATA_W-1:0] data_out,
  input logic              start_go,
  input logic              to_read,
  input logic              tmo_hit
);

  a_r2_start_enters_conv: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (busy && !adc_rc));

  a_r2_sw_start_port: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sw_start && !dac_busy) |=> busy);

  a_r4_dac_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dac_busy) |=> !busy);

  a_r5_read_level: assert property (@(posedge clk) disable iff (!rst_n)
    to_read |=> (busy && adc_rc));

  a_r6_timeout_exit: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!busy && tmo_flag && !done));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rc) |-> (!busy && done));

  a_r8_data_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> done);

  a_r10_cs_active: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (adc_cs == cs_act_high));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .dac_busy(dac_busy),
  .busy(busy), .adc_cs(adc_cs), .adc_rc(adc_rc), .cs_act_high(cs_act_high),
  .done(done), .tmo_flag(tmo_flag), .tmo_clr(tmo_clr), .data_out(data_out),
  .start_go(start_go), .to_read(to_read), .tmo_hit(tmo_hit)
);

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  conv_trig_in = '0;
  logic [1:0]  trig_sel = 2'd3;
  logic [2:0]  trig_fall = '0;
  logic        sw_start = 1'b0, dac_busy = 1'b0, rdy_in = 1'b0, rdy_fall = 1'b0;
  logic        open_loop = 1'b1;
  logic [15:0] conv_len = 16'd2, tmo_len = 16'd8, hold_len = 16'd1;
  logic        cs_act_high = 1'b1, wide_mode = 1'b1, tmo_clr = 1'b0;
  logic [15:0] adc_data_in = '0;
  logic        adc_cs, adc_rc, busy, done, tmo_flag;
  logic [15:0] data_out;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #2 clk = ~clk;

  adc_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .conv_trig_in(conv_trig_in), .trig_sel(trig_sel),
    .trig_fall(trig_fall), .sw_start(sw_start), .dac_busy(dac_busy), .rdy_in(rdy_in),
    .rdy_fall(rdy_fall), .open_loop(open_loop), .conv_len(conv_len), .tmo_len(tmo_len),
    .hold_len(hold_len), .cs_act_high(cs_act_high), .wide_mode(wide_mode),
    .adc_data_in(adc_data_in), .tmo_clr(tmo_clr), .adc_cs(adc_cs), .adc_rc(adc_rc),
    .busy(busy), .data_out(data_out), .done(done), .tmo_flag(tmo_flag)
  );

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (R1..all) actual=hung expected=finished");
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) step();
  endtask

  function automatic int eff(input logic [15:0] v);
    return (v == 16'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] d, input logic wide);
    return wide ? d : (d & 16'h00FF);
  endfunction

  // Closed-loop success: active ready edge lands within the timeout window.
  function automatic bit exp_ok(input logic ol, input int rdy_at, input bit act, input int t_eff);
    if (ol) return 1'b1;
    return (rdy_at >= 1) && act && (rdy_at + 2 <= t_eff);
  endfunction

  task automatic run_sw_conv(input int rdy_at, input bit noisy);
    int conv_c, read_c, guard, conv_exp, read_exp;
    bit cs_bad, ok, act;
    logic [15:0] old_data, want;
    conv_c = 0; read_c = 0; guard = 0; cs_bad = 0;
    old_data = data_out;
    act = (~rdy_in) ? !rdy_fall : rdy_fall;
    ok = exp_ok(open_loop, rdy_at, act, eff(tmo_len));
    conv_exp = open_loop ? eff(conv_len) : (ok ? rdy_at + 2 : eff(tmo_len));
    read_exp = ok ? eff(hold_len) : 0;
    want = ok ? exp_word(adc_data_in, wide_mode) : old_data;
    step(); step();
    sw_start = 1'b1;
    step();
    sw_start = 1'b0;
    chk(busy && !adc_rc, "R2 start enters convert", {busy, adc_rc}, 2'b10);
    while (busy && guard < 3000) begin
      guard++;
      if (adc_cs !== cs_act_high) cs_bad = 1'b1;
      if (!adc_rc) begin
        conv_c++;
        if (conv_c == rdy_at) rdy_in = ~rdy_in;
      end else read_c++;
      if (noisy) sw_start = 1'($urandom % 2);
      step();
    end
    sw_start = 1'b0;
    chk(!cs_bad, "R10 cs active level", cs_bad, 0);
    chk(adc_cs == !cs_act_high, "R10 cs idle level", adc_cs, !cs_act_high);
    chk(conv_c == conv_exp, open_loop ? "R7 convert length" : (ok ? "R5 ready length" : "R6 timeout length"),
        conv_c, conv_exp);
    chk(read_c == read_exp, "R8 read length", read_c, read_exp);
    chk(done == ok, ok ? "R8 done strobe" : "R6 no done on timeout", done, ok);
    chk(data_out == want, ok ? "R9 captured word" : "R6 data unchanged", data_out, want);
    chk(tmo_flag == !ok, "R6 timeout flag", tmo_flag, !ok);
    step();
    chk(!done, "R8 done one cycle", done, 0);
    if (!ok) begin
      step();
      chk(tmo_flag, "R6 flag sticky", tmo_flag, 1);
      tmo_clr = 1'b1;
      step();
      tmo_clr = 1'b0;
      chk(!tmo_flag, "R6 flag cleared", tmo_flag, 0);
    end
  endtask

  task automatic trig_start_test(input int k, input bit f);
    open_loop = 1'b1; conv_len = 16'd2; hold_len = 16'd1; trig_sel = 2'd3;
    if (f) begin conv_trig_in[k] = 1'b1; repeat (4) step(); end
    trig_fall[k] = f; trig_sel = 2'(k);
    repeat (3) step();
    conv_trig_in[k] = ~conv_trig_in[k];
    step(); chk(!busy, "R3 sync latency 1", busy, 0);
    step(); chk(!busy, "R3 sync latency 2", busy, 0);
    step(); chk(busy, "R3 trigger starts", busy, 1);
    wait_idle();
    trig_sel = 2'd3; conv_trig_in[k] = 1'b0; trig_fall[k] = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) step();
    chk(!busy && !done && !tmo_flag && !adc_rc && data_out == 0, "R1 reset outputs",
        {busy, done, tmo_flag, adc_rc}, 0);
    chk(adc_cs == 1'b0, "R1 cs inactive in reset", adc_cs, 0);
    rst_n = 1'b1;
    repeat (2) step();

    // Triggers on every input, both polarities.
    for (int k = 0; k < 3; k++) begin
      trig_start_test(k, 1'b0);
      trig_start_test(k, 1'b1);
    end

    // Inactive edge on the selected input.
    trig_sel = 2'd3; conv_trig_in[1] = 1'b1; repeat (4) step();
    trig_fall[1] = 1'b0; trig_sel = 2'd1; repeat (2) step();
    conv_trig_in[1] = 1'b0; repeat (6) step();
    chk(!busy, "R3 inactive edge ignored", busy, 0);

    // Edge on an unselected input.
    trig_sel = 2'd0; conv_trig_in[2] = 1'b1; repeat (6) step();
    chk(!busy, "R3 unselected input ignored", busy, 0);
    trig_sel = 2'd3; conv_trig_in[2] = 1'b0; repeat (4) step();

    // Triggers disabled.
    conv_trig_in = 3'b111; repeat (6) step();
    chk(!busy, "R3 trig_sel 3 disables", busy, 0);
    conv_trig_in = 3'b000; repeat (4) step();

    // DAC busy blocks software and trigger starts.
    dac_busy = 1'b1;
    sw_start = 1'b1; step(); sw_start = 1'b0; step();
    chk(!busy, "R4 sw start blocked by dac", busy, 0);
    trig_sel = 2'd0; conv_trig_in[0] = 1'b1; repeat (6) step();
    chk(!busy, "R4 trigger blocked by dac", busy, 0);
    trig_sel = 2'd3; conv_trig_in[0] = 1'b0; repeat (4) step();
    dac_busy = 1'b0;

    // Directed corners: zero lengths, ready on the last possible cycle, one too late.
    open_loop = 1'b1; conv_len = 16'd0; hold_len = 16'd0; wide_mode = 1'b0;
    adc_data_in = 16'hA5C3; run_sw_conv(0, 1'b0);
    open_loop = 1'b0; tmo_len = 16'd6; hold_len = 16'd2; wide_mode = 1'b1;
    rdy_fall = rdy_in; adc_data_in = 16'h3C5A; run_sw_conv(4, 1'b0);
    rdy_fall = rdy_in; adc_data_in = 16'h1111; run_sw_conv(5, 1'b0);
    rdy_fall = ~rdy_in; adc_data_in = 16'h2222; run_sw_conv(2, 1'b0);

    // Random conversions.
    for (int it = 0; it < 60; it++) begin
      open_loop   = 1'($urandom % 2);
      conv_len    = 16'($urandom % 20);
      tmo_len     = 16'($urandom % 20);
      hold_len    = 16'($urandom % 6);
      rdy_fall    = 1'($urandom % 2);
      cs_act_high = 1'($urandom % 2);
      wide_mode   = 1'($urandom % 2);
      adc_data_in = 16'($urandom);
      run_sw_conv(1 + int'($urandom % 22), 1'($urandom % 2));
    end

    summary_and_end();
  end

endmodule